// File: doc/BRIEF.md
# Hardware Monitor Interrupt Status and Mask Bank

This block collects out-of-limit events from the comparators of a hardware monitor and turns them into one active-high interrupt line. It has two status registers. Each one latches an event from a voltage, temperature, fan or enclosure-intrusion comparator when the event arrives. It has two mask registers, which decide which latched events may drive the interrupt. Software reaches all four registers over a simple byte-wide register bus with separate read and write strobes.

Reading a status register clears the bits it returned. The enclosure-intrusion bit is the exception. It survives any number of reads and clears only when its own clear input is pulsed. An event input that is still active keeps its bit set, so a condition that has not gone away raises the interrupt again. The top bit of the second mask register is not a mask. It is a reset-enable control, and the block drives it out to the configuration logic.

Top module: `hwmon_irq_bank`

## Requirements
- R1: After reset, every register reads 00h, `irq` is 0 and `rst_en` is 0.
- R2: Status register A is at address 0x41. Its bits are: bit 0 +2.5V, bit 1 core supply 1, bit 2 +3.3V, bit 3 +5V, bit 4 temperature, bit 6 fan 1, bit 7 fan 2. Status register B is at address 0x42. Its bits are: bit 0 +12V, bit 1 -12V / core supply 2, bit 4 enclosure intrusion. An event input that is high at a clock edge sets its bit. All other bit positions always read 0.
- R3: A read strobe latches the addressed register onto `bus_rdata` at that clock edge. On a status register, the same edge clears the bits that can be cleared by a read.
- R4: A read never clears the enclosure-intrusion bit (bit 4 of status register B). A one-cycle pulse on `chs_clr` clears it.
- R5: If an event input is high in the same cycle as a clearing read, the set wins and the bit stays 1.
- R6: Mask register A (0x43, same bit positions as status register A) and mask register B (0x44) are read/write on all 8 bits, reserved bits included.
- R7: `irq` is the registered OR of every status bit whose mask bit is 0. It rises one clock after the status bit sets.
- R8: A masked source still latches its status bit. Masking blocks only `irq`.
- R9: Bit 7 of mask register B drives `rst_en` and has no effect on `irq`.
- R10: Reads of any other address return 00h. Writes to the status registers leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_grp1 | input | 8 | Event inputs for status register A (bit 5 unused) |
| evt_grp2 | input | 8 | Event inputs for status register B (bits 0, 1 and 4 used) |
| chs_clr | input | 1 | Clear pulse for the enclosure-intrusion bit |
| irq | output | 1 | Interrupt, active high |
| rst_en | output | 1 | Reset-enable control bit |

## Verification
The bench builds the block with its default parameters: registers at 0x41 to 0x44, the seven-bit and three-bit implemented patterns, intrusion as the only sticky bit, and a registered interrupt. With this build, the one-cycle lag of `irq` behind a status bit can be measured at the ports. It also lets the bench hold an event high across a clearing read, which is the race between set and clear. The same build exposes the split between the sticky intrusion bit and its neighbours, which clear on read. Addresses next to the mapped window (0x40 and 0x45) show that decoding stops at the window edges.

// File: rtl/hwmon_irq_pkg.sv
package hwmon_irq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_STAT1 = 3'd1,
      SEL_STAT2 = 3'd2,
      SEL_MASK1 = 3'd3,
      SEL_MASK2 = 3'd4
   } reg_sel_e;

   localparam int unsigned BYTE_W = 8;

   localparam logic [BYTE_W-1:0] ADDR_STAT1_DEF   = 8'h41;
   localparam logic [BYTE_W-1:0] ADDR_STAT2_DEF   = 8'h42;
   localparam logic [BYTE_W-1:0] ADDR_MASK1_DEF   = 8'h43;
   localparam logic [BYTE_W-1:0] ADDR_MASK2_DEF   = 8'h44;

   localparam logic [BYTE_W-1:0] STAT1_IMPL_DEF   = 8'hDF;
   localparam logic [BYTE_W-1:0] STAT2_IMPL_DEF   = 8'h13;
   localparam logic [BYTE_W-1:0] STAT2_STICKY_DEF = 8'h10;

endpackage

// File: rtl/hwmon_addr_dec.sv
module hwmon_addr_dec
   import hwmon_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] A_STAT1 = '0,
   parameter logic [ADDR_W-1:0] A_STAT2 = '0,
   parameter logic [ADDR_W-1:0] A_MASK1 = '0,
   parameter logic [ADDR_W-1:0] A_MASK2 = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   always_comb begin
      if (addr == A_STAT1)      sel = SEL_STAT1;
      else if (addr == A_STAT2) sel = SEL_STAT2;
      else if (addr == A_MASK1) sel = SEL_MASK1;
      else if (addr == A_MASK2) sel = SEL_MASK2;
      else                      sel = SEL_NONE;
   end

endmodule

// File: rtl/hwmon_status_reg.sv
module hwmon_status_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] IMPL   = '1,
   parameter logic [W-1:0] STICKY = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         rd_clr,
   input  logic         sticky_clr,
   output logic [W-1:0] q
);

   logic unused_rsvd_evt;
   assign unused_rsvd_evt = ^(evt & ~IMPL) ^ rd_clr ^ sticky_clr;

   for (genvar gi = 0; gi < W; gi++) begin : g_bit
      if (!IMPL[gi]) begin : g_rsvd
         assign q[gi] = 1'b0;
      end else if (STICKY[gi]) begin : g_sticky
         logic b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          b_q <= 1'b0;
            else if (evt[gi])    b_q <= 1'b1;
            else if (sticky_clr) b_q <= 1'b0;
         end
         assign q[gi] = b_q;
      end else begin : g_rdclr
         logic b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       b_q <= 1'b0;
            else if (evt[gi]) b_q <= 1'b1;
            else if (rd_clr)  b_q <= 1'b0;
         end
         assign q[gi] = b_q;
      end
   end

endmodule

// File: rtl/hwmon_mask_reg.sv
module hwmon_mask_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= wdata;
   end

endmodule

// File: rtl/hwmon_irq_gen.sv
module hwmon_irq_gen #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] IMPL1 = '1,
   parameter logic [W-1:0] IMPL2 = '1,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat1,
   input  logic [W-1:0] mask1,
   input  logic [W-1:0] stat2,
   input  logic [W-1:0] mask2,
   output logic         irq
);

   logic [W-1:0] live1, live2;
   logic         pending;

   assign live1   = stat1 & ~mask1 & IMPL1;
   assign live2   = stat2 & ~mask2 & IMPL2;
   assign pending = |{live1, live2};

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = pending;
   end

endmodule

// File: rtl/hwmon_irq_bank.sv
module hwmon_irq_bank
   import hwmon_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = BYTE_W,
   parameter logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(ADDR_STAT1_DEF),
   parameter logic [ADDR_W-1:0] A_STAT2 = ADDR_W'(ADDR_STAT2_DEF),
   parameter logic [ADDR_W-1:0] A_MASK1 = ADDR_W'(ADDR_MASK1_DEF),
   parameter logic [ADDR_W-1:0] A_MASK2 = ADDR_W'(ADDR_MASK2_DEF),
   parameter logic [DATA_W-1:0] STAT1_IMPL   = DATA_W'(STAT1_IMPL_DEF),
   parameter logic [DATA_W-1:0] STAT2_IMPL   = DATA_W'(STAT2_IMPL_DEF),
   parameter logic [DATA_W-1:0] STAT2_STICKY = DATA_W'(STAT2_STICKY_DEF),
   parameter int unsigned RST_EN_BIT = DATA_W - 1,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] evt_grp1,
   input  logic [DATA_W-1:0] evt_grp2,
   input  logic              chs_clr,
   output logic              irq,
   output logic              rst_en
);

   localparam logic [DATA_W-1:0] NO_STICKY = '0;

   // elaboration-time parameter checks
   if (A_STAT1 == A_STAT2 || A_STAT1 == A_MASK1 || A_STAT1 == A_MASK2 ||
       A_STAT2 == A_MASK1 || A_STAT2 == A_MASK2 || A_MASK1 == A_MASK2) begin : g_bad_addr
      $error("hwmon_irq_bank: register addresses must be distinct");
   end
   if ((STAT2_STICKY & ~STAT2_IMPL) != '0) begin : g_bad_sticky
      $error("hwmon_irq_bank: sticky bits must be implemented bits");
   end
   if (RST_EN_BIT >= DATA_W) begin : g_bad_rsten
      $error("hwmon_irq_bank: reset-enable bit outside data width");
   end
   if (RST_EN_BIT < DATA_W && STAT2_IMPL[RST_EN_BIT % DATA_W]) begin : g_bad_overlap
      $error("hwmon_irq_bank: reset-enable bit overlaps a status-B source");
   end

   reg_sel_e          sel;
   logic              rd_s1, rd_s2, wr_m1, wr_m2;
   logic [DATA_W-1:0] stat1_q, stat2_q, mask1_q, mask2_q;
   logic [DATA_W-1:0] rd_mux, rdata_q;

   hwmon_addr_dec #(
      .ADDR_W (ADDR_W),
      .A_STAT1(A_STAT1),
      .A_STAT2(A_STAT2),
      .A_MASK1(A_MASK1),
      .A_MASK2(A_MASK2)
   ) u_dec (
      .addr(bus_addr),
      .sel (sel)
   );

   assign rd_s1 = bus_rd && (sel == SEL_STAT1);
   assign rd_s2 = bus_rd && (sel == SEL_STAT2);
   assign wr_m1 = bus_wr && (sel == SEL_MASK1);
   assign wr_m2 = bus_wr && (sel == SEL_MASK2);

   hwmon_status_reg #(
      .W     (DATA_W),
      .IMPL  (STAT1_IMPL),
      .STICKY(NO_STICKY)
   ) u_stat1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt_grp1),
      .rd_clr    (rd_s1),
      .sticky_clr(1'b0),
      .q         (stat1_q)
   );

   hwmon_status_reg #(
      .W     (DATA_W),
      .IMPL  (STAT2_IMPL),
      .STICKY(STAT2_STICKY)
   ) u_stat2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt_grp2),
      .rd_clr    (rd_s2),
      .sticky_clr(chs_clr),
      .q         (stat2_q)
   );

   hwmon_mask_reg #(.W(DATA_W), .RST_VAL('0)) u_mask1 (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_m1),
      .wdata(bus_wdata),
      .q    (mask1_q)
   );

   hwmon_mask_reg #(.W(DATA_W), .RST_VAL('0)) u_mask2 (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_m2),
      .wdata(bus_wdata),
      .q    (mask2_q)
   );

   hwmon_irq_gen #(
      .W      (DATA_W),
      .IMPL1  (STAT1_IMPL),
      .IMPL2  (STAT2_IMPL),
      .IRQ_REG(IRQ_REG)
   ) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .stat1(stat1_q),
      .mask1(mask1_q),
      .stat2(stat2_q),
      .mask2(mask2_q),
      .irq  (irq)
   );

   always_comb begin
      case (sel)
         SEL_STAT1: rd_mux = stat1_q;
         SEL_STAT2: rd_mux = stat2_q;
         SEL_MASK1: rd_mux = mask1_q;
         SEL_MASK2: rd_mux = mask2_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
   assign rst_en    = mask2_q[RST_EN_BIT % DATA_W];

endmodule

// File: rtl/hwmon_irq_bank_chk.sv
module hwmon_irq_bank_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] A_STAT1 = '0,
   parameter logic [ADDR_W-1:0] A_STAT2 = '0,
   parameter logic [ADDR_W-1:0] A_MASK1 = '0,
   parameter logic [ADDR_W-1:0] A_MASK2 = '0,
   parameter logic [DATA_W-1:0] STAT1_IMPL   = '0,
   parameter logic [DATA_W-1:0] STAT2_IMPL   = '0,
   parameter logic [DATA_W-1:0] STAT2_STICKY = '0,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] evt_grp1,
   input logic [DATA_W-1:0] evt_grp2,
   input logic              chs_clr,
   input logic              irq,
   input logic [DATA_W-1:0] stat1_q,
   input logic [DATA_W-1:0] stat2_q,
   input logic [DATA_W-1:0] mask1_q,
   input logic [DATA_W-1:0] mask2_q
);

   logic unmapped;
   assign unmapped = (bus_addr != A_STAT1) && (bus_addr != A_STAT2) &&
                     (bus_addr != A_MASK1) && (bus_addr != A_MASK2);

   p_event_sets_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_grp1 & STAT1_IMPL) != '0) |=>
      ((stat1_q & $past(evt_grp1 & STAT1_IMPL)) == $past(evt_grp1 & STAT1_IMPL)));

   p_event_sets_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_grp2 & STAT2_IMPL) != '0) |=>
      ((stat2_q & $past(evt_grp2 & STAT2_IMPL)) == $past(evt_grp2 & STAT2_IMPL)));

   p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_STAT1 && evt_grp1 == '0) |=> (stat1_q == '0));

   p_chassis_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_STAT2 && !chs_clr &&
       (stat2_q & STAT2_STICKY) == STAT2_STICKY) |=>
      ((stat2_q & STAT2_STICKY) == STAT2_STICKY));

   p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MASK1) |=> (mask1_q == $past(bus_wdata)));

   if (IRQ_REG) begin : g_irq_chk
      p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|((stat1_q & ~mask1_q & STAT1_IMPL) |
                                  (stat2_q & ~mask2_q & STAT2_IMPL)))));
   end else begin : g_irq_comb_chk
      p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (((stat1_q & ~mask1_q & STAT1_IMPL) | (stat2_q & ~mask2_q & STAT2_IMPL)) == '0)
         |-> !irq);
   end

   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |=> (bus_rdata == '0));

   p_status_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rd && bus_addr == A_STAT1 && evt_grp1 == '0) |=> $stable(stat1_q));

endmodule

bind hwmon_irq_bank hwmon_irq_bank_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .A_STAT1     (A_STAT1),
   .A_STAT2     (A_STAT2),
   .A_MASK1     (A_MASK1),
   .A_MASK2     (A_MASK2),
   .STAT1_IMPL  (STAT1_IMPL),
   .STAT2_IMPL  (STAT2_IMPL),
   .STAT2_STICKY(STAT2_STICKY),
   .IRQ_REG     (IRQ_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .evt_grp1 (evt_grp1),
   .evt_grp2 (evt_grp2),
   .chs_clr  (chs_clr),
   .irq      (irq),
   .stat1_q  (stat1_q),
   .stat2_q  (stat2_q),
   .mask1_q  (mask1_q),
   .mask2_q  (mask2_q)
);

// File: tb/tb_hwmon_irq_bank.sv
module tb_hwmon_irq_bank;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] evt_grp1 = '0;
   logic [7:0] evt_grp2 = '0;
   logic       chs_clr = 1'b0;
   logic       irq;
   logic       rst_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hwmon_irq_bank dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .evt_grp1 (evt_grp1),
      .evt_grp2 (evt_grp2),
      .chs_clr  (chs_clr),
      .irq      (irq),
      .rst_en   (rst_en)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      @(posedge clk);
      #1;
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
   endtask

   task automatic pulse_evt(input logic [7:0] g1, input logic [7:0] g2);
      @(negedge clk);
      evt_grp1 = g1;
      evt_grp2 = g2;
      @(posedge clk);
      #1;
      evt_grp1 = '0;
      evt_grp2 = '0;
   endtask

   task automatic pulse_chs_clr();
      @(negedge clk);
      chs_clr = 1'b1;
      @(posedge clk);
      #1;
      chs_clr = 1'b0;
   endtask

   task automatic clean_up();
      logic [7:0] d;
      bus_read(8'h41, d);
      bus_read(8'h42, d);
      pulse_chs_clr();
      bus_write(8'h43, 8'h00);
      bus_write(8'h44, 8'h00);
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1", "irq after reset", {7'b0, irq}, 8'h00);
      check("R1", "rst_en after reset", {7'b0, rst_en}, 8'h00);
      check("R1", "rdata after reset", bus_rdata, 8'h00);
      for (int i = 8'h41; i <= 8'h44; i++) begin
         bus_read(8'(i), d);
         check("R1", "register after reset", d, 8'h00);
      end
   endtask

   task automatic t_latch_and_clear();
      logic [7:0] d;
      // R2: bit 5 of status A and bits 2,3,5,6,7 of status B are not implemented
      pulse_evt(8'hFF, 8'hFF);
      bus_read(8'h41, d);
      check("R2", "status A layout", d, 8'hDF);
      bus_read(8'h41, d);
      check("R3", "status A cleared by read", d, 8'h00);
      bus_read(8'h42, d);
      check("R2", "status B layout", d, 8'h13);
      bus_read(8'h42, d);
      check("R4", "intrusion bit survives read", d, 8'h10);
      bus_read(8'h42, d);
      check("R4", "intrusion bit survives second read", d, 8'h10);
      pulse_chs_clr();
      bus_read(8'h42, d);
      check("R4", "intrusion bit cleared by chs_clr", d, 8'h00);
      clean_up();
   endtask

   task automatic t_irq_timing();
      logic [7:0] d;
      pulse_evt(8'h01, 8'h00);
      check("R7", "irq one cycle after status sets: still 0", {7'b0, irq}, 8'h00);
      @(posedge clk);
      #1;
      check("R7", "irq rises one cycle later", {7'b0, irq}, 8'h01);
      bus_read(8'h41, d);
      @(posedge clk);
      #1;
      check("R7", "irq falls after status cleared", {7'b0, irq}, 8'h00);
      pulse_evt(8'h00, 8'h02);
      @(posedge clk);
      #1;
      check("R7", "irq from status B source", {7'b0, irq}, 8'h01);
      clean_up();
   endtask

   task automatic t_masking();
      logic [7:0] d;
      bus_write(8'h43, 8'hFF);
      bus_write(8'h44, 8'h7F);
      pulse_evt(8'h08, 8'h01);
      repeat (3) @(posedge clk);
      #1;
      check("R8", "masked sources keep irq low", {7'b0, irq}, 8'h00);
      bus_write(8'h43, 8'hF7);
      @(posedge clk);
      #1;
      check("R7", "unmasking a set bit raises irq", {7'b0, irq}, 8'h01);
      bus_read(8'h41, d);
      check("R8", "masked source latched in status A", d, 8'h08);
      bus_read(8'h42, d);
      check("R8", "masked source latched in status B", d, 8'h01);
      clean_up();
   endtask

   task automatic t_set_wins();
      logic [7:0] d;
      @(negedge clk);
      evt_grp1 = 8'h40;
      bus_read(8'h41, d);
      check("R5", "first read while event held", d, 8'h40);
      bus_read(8'h41, d);
      check("R5", "bit set again during clearing read", d, 8'h40);
      @(negedge clk);
      evt_grp1 = 8'h00;
      bus_read(8'h41, d);
      check("R5", "last set survives until next read", d, 8'h40);
      bus_read(8'h41, d);
      check("R3", "cleared once event gone", d, 8'h00);
      clean_up();
   endtask

   task automatic t_mask_rw();
      logic [7:0] d;
      bus_write(8'h43, 8'hA5);
      bus_read(8'h43, d);
      check("R6", "mask A readback", d, 8'hA5);
      bus_write(8'h44, 8'h6C);
      bus_read(8'h44, d);
      check("R6", "mask B readback with reserved bits", d, 8'h6C);
      check("R9", "rst_en low while bit 7 clear", {7'b0, rst_en}, 8'h00);
      clean_up();
   endtask

   task automatic t_rst_en();
      bus_write(8'h44, 8'h80);
      check("R9", "rst_en follows mask B bit 7", {7'b0, rst_en}, 8'h01);
      pulse_evt(8'h00, 8'h01);
      @(posedge clk);
      #1;
      check("R9", "bit 7 does not mask irq", {7'b0, irq}, 8'h01);
      clean_up();
      check("R9", "rst_en low after clearing", {7'b0, rst_en}, 8'h00);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      bus_write(8'h43, 8'h5A);
      bus_read(8'h40, d);
      check("R10", "read below window", d, 8'h00);
      bus_read(8'h45, d);
      check("R10", "read above window", d, 8'h00);
      bus_read(8'h00, d);
      check("R10", "read at 00h", d, 8'h00);
      bus_write(8'h41, 8'hFF);
      bus_read(8'h41, d);
      check("R10", "write to status A ignored", d, 8'h00);
      pulse_evt(8'h00, 8'h10);
      bus_write(8'h42, 8'h00);
      bus_read(8'h42, d);
      check("R10", "write to status B ignored", d, 8'h10);
      clean_up();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_latch_and_clear();
      t_irq_timing();
      t_masking();
      t_set_wins();
      t_mask_rw();
      t_rst_en();
      t_unmapped();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule